// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a processor's virtual address into a physical address by looking up a single-level page table in memory. A request carries a virtual address and an access kind: load, store or instruction fetch. The block splits the address into a page number and an in-page offset. It adds the page number, scaled by the entry size, to a table base register. It then issues one read on a simple memory port and decodes the byte that comes back.

The returned entry carries a presence flag, a rights field and a physical page number. The block reports one of three results: a physical address, a not-present fault, or a protection fault when the access kind is not allowed by the rights. Each process keeps its own table. Software switches between tables by loading a new base value. The block only reports faults and does not handle them.

Default geometry: 1 KB pages, 32 virtual pages, 8 physical pages, 16-bit table addresses and one-byte entries.

Top module: `pt_xlate`

## Requirements
- R1: While reset is held, and after it is released, `req_ready` is 1 and `mem_req` and `rsp_valid` are 0 until a request arrives.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 from the next cycle until the cycle after the response pulse, and only one translation is in flight at a time.
- R3: In the cycle after a request is taken, `mem_req` is 1 for exactly one cycle. In that cycle, `mem_addr` equals the base value plus the virtual page number (bits 14:10 of `req_vaddr`), taken modulo 2^16 because an entry is one byte.
- R4: A base write (`pt_base_we` high at a clock edge) applies to requests taken at later edges. A request taken on the same edge uses the old base. A base write while a walk is in flight does not change that walk's `mem_addr`.
- R5: The entry byte is decoded as follows: bit 7 is the presence flag, bits 6:5 are the rights field, and bits 2:0 are the physical page number. Bits 4:3 have no effect on the result.
- R6: An entry with bit 7 equal to 0 yields `rsp_fault` = 01 (not present), whatever its rights field holds.
- R7: The access kind `req_kind` is encoded 00 load, 01 store, 10 fetch, 11 reserved. The rights field is encoded 00 read-only, 01 read/write, 10 executable, 11 reserved. A load is allowed for rights 00, 01 and 10. A store is allowed only for 01. A fetch is allowed only for 10. Kind 11 and rights 11 always give `rsp_fault` = 10 (protection).
- R8: An allowed access yields `rsp_fault` = 00 and `rsp_paddr` = {entry bits 2:0, `req_vaddr` bits 9:0}. `rsp_paddr` carries no meaning when the fault code is nonzero.
- R9: `mem_rdata` is sampled only on the first edge with `mem_rvalid` = 1 after the read is issued. `rsp_valid` is a one-cycle pulse in the cycle after that edge. A `mem_rvalid` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_base_we | input | 1 | Load a new table base |
| pt_base_wdata | input | 16 | New table base value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can take a request |
| req_vaddr | input | 15 | Virtual address |
| req_kind | input | 2 | Access kind (00 load, 01 store, 10 fetch) |
| mem_req | output | 1 | One-cycle table read strobe |
| mem_addr | output | 16 | Table entry address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Table entry read data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 2 | 00 none, 01 not present, 10 protection |
| rsp_paddr | output | 13 | Physical address |

## Verification
The hardest situation to reach from the ports is a base write that lands in the same cycle as a request, or in the middle of a walk. The walk must keep its old entry address, and the next request must use the new one. The bench reaches it by moving the base-write strobe onto the acceptance edge, and then onto the issue cycle, of a chosen translation. It follows each case with a lookup that can only succeed through the new table. The bench also varies the memory latency and adds a base that wraps past the top of the table address space.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

  localparam int ENT_W     = 8;
  localparam int ENT_V_BIT = 7;
  localparam int ENT_R_HI  = 6;
  localparam int ENT_R_LO  = 5;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    RT_RO   = 2'b00,
    RT_RW   = 2'b01,
    RT_EX   = 2'b10,
    RT_RSVD = 2'b11
  } rights_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_ABSENT = 2'b01,
    FLT_PROT   = 2'b10
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_WAIT  = 2'b10,
    ST_RESP  = 2'b11
  } walk_st_e;

endpackage

// File: rtl/pt_rst_sync.sv
module pt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pt_base_reg.sv
module pt_base_reg #(
  parameter int MA_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [MA_W-1:0] wr_data,
  output logic [MA_W-1:0] base_q
);

  logic [MA_W-1:0] base_d;

  always_comb begin
    base_d = base_q;
    if (wr_en) base_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (wr_en) begin
      base_q <= base_d;
    end
  end

endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_xlate_pkg::*;
#(
  parameter  int PPN_W = 3,
  parameter  int OFF_W = 10,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic             ent_v,
  input  rights_e          ent_rights,
  input  logic [PPN_W-1:0] ent_ppn,
  input  acc_e             kind,
  input  logic [OFF_W-1:0] off,
  output fault_e           fault,
  output logic [PA_W-1:0]  paddr
);

  logic allowed;

  always_comb begin
    allowed = 1'b0;
    case (kind)
      ACC_LOAD:  allowed = (ent_rights != RT_RSVD);
      ACC_STORE: allowed = (ent_rights == RT_RW);
      ACC_FETCH: allowed = (ent_rights == RT_EX);
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (!ent_v)        fault = FLT_ABSENT;
    else if (!allowed) fault = FLT_PROT;
    else               fault = FLT_NONE;
  end

  assign paddr = {ent_ppn, off};

endmodule

// File: rtl/pt_walk_ctl.sv
module pt_walk_ctl
  import pt_xlate_pkg::*;
#(
  parameter  int VPN_W = 5,
  parameter  int OFF_W = 10,
  parameter  int PPN_W = 3,
  parameter  int MA_W  = 16,
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int ENT_SHIFT = $clog2(ENT_W / 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic [MA_W-1:0]  base_q,
  output logic             mem_req,
  output logic [MA_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [ENT_W-1:0] mem_rdata,
  output logic             rsp_valid,
  output logic             ent_v,
  output rights_e          ent_rights,
  output logic [PPN_W-1:0] ent_ppn,
  output acc_e             kind_q,
  output logic [OFF_W-1:0] off_q
);

  walk_st_e        state_q, state_d;
  logic            accept, capture;
  logic [MA_W-1:0] addr_q, addr_d;
  logic [ENT_W-1:0] rdata_unused;

  assign rdata_unused = mem_rdata;
  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign capture = (state_q == ST_WAIT) && mem_rvalid;
  assign addr_d  = base_q + (MA_W'(req_vaddr[VA_W-1:OFF_W]) << ENT_SHIFT);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_valid)  state_d = ST_ISSUE;
      ST_ISSUE:                 state_d = ST_WAIT;
      ST_WAIT:  if (mem_rvalid) state_d = ST_RESP;
      ST_RESP:                  state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      off_q      <= '0;
      kind_q     <= ACC_LOAD;
      ent_v      <= 1'b0;
      ent_rights <= RT_RO;
      ent_ppn    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= addr_d;
        off_q  <= req_vaddr[OFF_W-1:0];
        kind_q <= acc_e'(req_kind);
      end
      if (capture) begin
        ent_v      <= mem_rdata[ENT_V_BIT];
        ent_rights <= rights_e'(mem_rdata[ENT_R_HI:ENT_R_LO]);
        ent_ppn    <= mem_rdata[PPN_W-1:0];
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_ISSUE);
  assign rsp_valid = (state_q == ST_RESP);
  assign mem_addr  = addr_q;

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && mem_req));
  a_r3_mem_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(mem_addr));
  a_r9_rsp_follows_data: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && mem_rvalid) |=> rsp_valid);
  a_r9_rsp_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
  import pt_xlate_pkg::*;
#(
  parameter  int PAGE_BYTES = 1024,
  parameter  int VPAGES     = 32,
  parameter  int PPAGES     = 8,
  parameter  int MA_W       = 16,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int VPN_W = $clog2(VPAGES),
  localparam int PPN_W = $clog2(PPAGES),
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pt_base_we,
  input  logic [MA_W-1:0]  pt_base_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  output logic             mem_req,
  output logic [MA_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [7:0]       mem_rdata,
  output logic             rsp_valid,
  output logic [1:0]       rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr
);

  logic             rst_sync_n;
  logic [MA_W-1:0]  base_q;
  logic             ent_v;
  rights_e          ent_rights;
  logic [PPN_W-1:0] ent_ppn;
  acc_e             kind_q;
  logic [OFF_W-1:0] off_q;
  fault_e           fault;

  pt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pt_base_reg #(.MA_W(MA_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (pt_base_we),
    .wr_data (pt_base_wdata),
    .base_q  (base_q)
  );

  pt_walk_ctl #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .MA_W(MA_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vaddr  (req_vaddr),
    .req_kind   (req_kind),
    .base_q     (base_q),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .rsp_valid  (rsp_valid),
    .ent_v      (ent_v),
    .ent_rights (ent_rights),
    .ent_ppn    (ent_ppn),
    .kind_q     (kind_q),
    .off_q      (off_q)
  );

  pt_entry_check #(.PPN_W(PPN_W), .OFF_W(OFF_W)) u_chk (
    .ent_v      (ent_v),
    .ent_rights (ent_rights),
    .ent_ppn    (ent_ppn),
    .kind       (kind_q),
    .off        (off_q),
    .fault      (fault),
    .paddr      (rsp_paddr)
  );

  assign rsp_fault = fault;

  a_r6_absent_reported: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && !ent_v) |-> (rsp_fault == FLT_ABSENT));
  a_r8_offset_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && rsp_fault == FLT_NONE) |-> (rsp_paddr[OFF_W-1:0] == off_q));

  initial begin
    a_r5_geometry: assert (PPN_W <= 3 && VPN_W < MA_W);
  end

endmodule

// File: tb/pt_xlate_tb.sv
module pt_xlate_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pt_base_we;
  logic [15:0] pt_base_wdata;
  logic        req_valid;
  logic        req_ready;
  logic [14:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid;
  logic [7:0]  mem_rdata;
  logic        rsp_valid;
  logic [1:0]  rsp_fault;
  logic [12:0] rsp_paddr;

  always #5 clk = ~clk;

  pt_xlate u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .pt_base_we    (pt_base_we),
    .pt_base_wdata (pt_base_wdata),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_kind      (req_kind),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rvalid    (mem_rvalid),
    .mem_rdata     (mem_rdata),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_paddr     (rsp_paddr)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [7:0]  mem_bytes [int];
  logic [15:0] cur_base;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_fault(input logic [7:0] e, input logic [1:0] k);
    logic ok;
    if (!e[7]) return 2'b01;
    case (k)
      2'b00:   ok = (e[6:5] != 2'b11);
      2'b01:   ok = (e[6:5] == 2'b01);
      2'b10:   ok = (e[6:5] == 2'b10);
      default: ok = 1'b0;
    endcase
    return ok ? 2'b00 : 2'b10;
  endfunction

  task automatic set_base(input logic [15:0] nb);
    @(negedge clk);
    pt_base_we = 1'b1;
    pt_base_wdata = nb;
    cur_base = nb;
    @(negedge clk);
    pt_base_we = 1'b0;
  endtask

  // wr_at: -1 no base write, 0 on acceptance edge, 1 during the issue cycle
  task automatic xlate(input logic [4:0] vpn, input logic [9:0] off, input logic [1:0] kind,
                       input int lat, input int wr_at, input logic [15:0] nb, input string rq);
    logic [15:0] ea;
    logic [7:0]  e;
    logic [1:0]  ef;
    ea = cur_base + {11'd0, vpn};
    e  = mem_bytes.exists(int'(ea)) ? mem_bytes[int'(ea)] : 8'h00;
    ef = ref_fault(e, kind);
    @(negedge clk);
    chk("R2", "ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_vaddr = {vpn, off};
    req_kind  = kind;
    if (wr_at == 0) begin
      pt_base_we = 1'b1; pt_base_wdata = nb; cur_base = nb;
    end
    @(negedge clk);
    req_valid  = 1'b0;
    req_vaddr  = 15'h7FFF;
    pt_base_we = 1'b0;
    if (wr_at == 1) begin
      pt_base_we = 1'b1; pt_base_wdata = nb; cur_base = nb;
    end
    chk("R2", "ready while busy", 32'(req_ready), 32'd0);
    chk("R3", "mem_req pulse", 32'(mem_req), 32'd1);
    chk(rq, "entry address", 32'(mem_addr), 32'(ea));
    chk("R9", "no early response", 32'(rsp_valid), 32'd0);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      pt_base_we = 1'b0;
      chk("R3", "mem_req single", 32'(mem_req), 32'd0);
      chk("R9", "rsp while waiting", 32'(rsp_valid), 32'd0);
      chk("R2", "ready while waiting", 32'(req_ready), 32'd0);
    end
    @(negedge clk);
    pt_base_we = 1'b0;
    mem_rvalid = 1'b1;
    mem_rdata  = e;
    chk("R3", "mem_req single", 32'(mem_req), 32'd0);
    chk("R9", "rsp before data", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    mem_rvalid = 1'b0;
    mem_rdata  = 8'h3C;
    chk("R9", "rsp pulse", 32'(rsp_valid), 32'd1);
    chk(rq, "fault code", 32'(rsp_fault), 32'(ef));
    if (ef == 2'b00) chk("R8", "physical address", 32'(rsp_paddr), 32'({e[2:0], off}));
    chk("R2", "ready during response", 32'(req_ready), 32'd0);
    @(negedge clk);
    chk("R9", "rsp one cycle", 32'(rsp_valid), 32'd0);
    chk("R2", "ready after response", 32'(req_ready), 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pt_base_we = 1'b0;
    pt_base_wdata = '0;
    req_valid = 1'b0;
    req_vaddr = '0;
    req_kind = 2'b00;
    mem_rvalid = 1'b0;
    mem_rdata = '0;
    cur_base = 16'h0000;

    mem_bytes[16'h0103] = 8'hA5;  // RW, ppn 5
    mem_bytes[16'h0104] = 8'h82;  // RO, ppn 2
    mem_bytes[16'h0105] = 8'hC7;  // EX, ppn 7
    mem_bytes[16'h0106] = 8'h23;  // absent, RW bits
    mem_bytes[16'h0107] = 8'hE1;  // reserved rights
    mem_bytes[16'h0108] = 8'hBE;  // RW, ppn 6, bits 4:3 set
    mem_bytes[16'h0100] = 8'hA1;  // vpn 0: RW, ppn 1
    mem_bytes[16'h011F] = 8'hC0;  // vpn 31: EX, ppn 0
    mem_bytes[16'h0203] = 8'h81;  // second table: RO, ppn 1
    mem_bytes[16'h0303] = 8'hA4;  // third table: RW, ppn 4
    mem_bytes[16'h000F] = 8'hA3;  // wrapped address: RW, ppn 3

    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", 32'(req_ready), 32'd1);
    chk("R1", "mem_req in reset", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "ready after reset", 32'(req_ready), 32'd1);
    chk("R1", "mem_req after reset", 32'(mem_req), 32'd0);
    chk("R1", "rsp after reset", 32'(rsp_valid), 32'd0);

    set_base(16'h0100);
    xlate(5'd3, 10'h155, 2'b00, 0, -1, 16'h0, "R7 load RW");
    xlate(5'd3, 10'h2AA, 2'b01, 3, -1, 16'h0, "R7 store RW");
    xlate(5'd3, 10'h001, 2'b10, 1, -1, 16'h0, "R7 fetch RW");
    xlate(5'd4, 10'h3FF, 2'b00, 2, -1, 16'h0, "R7 load RO");
    xlate(5'd4, 10'h010, 2'b01, 0, -1, 16'h0, "R7 store RO");
    xlate(5'd4, 10'h020, 2'b10, 5, -1, 16'h0, "R7 fetch RO");
    xlate(5'd5, 10'h0F0, 2'b10, 1, -1, 16'h0, "R7 fetch EX");
    xlate(5'd5, 10'h0F1, 2'b00, 0, -1, 16'h0, "R7 load EX");
    xlate(5'd5, 10'h0F2, 2'b01, 2, -1, 16'h0, "R7 store EX");
    xlate(5'd6, 10'h123, 2'b00, 1, -1, 16'h0, "R6 absent load");
    xlate(5'd6, 10'h123, 2'b10, 0, -1, 16'h0, "R6 absent fetch");
    xlate(5'd7, 10'h200, 2'b00, 0, -1, 16'h0, "R7 reserved rights");
    xlate(5'd3, 10'h200, 2'b11, 0, -1, 16'h0, "R7 reserved kind");
    xlate(5'd8, 10'h3A5, 2'b01, 1, -1, 16'h0, "R5 ignored bits");
    xlate(5'd0, 10'h000, 2'b00, 0, -1, 16'h0, "R3 vpn zero");
    xlate(5'd31, 10'h3FF, 2'b10, 4, -1, 16'h0, "R3 vpn top");

    // R9: stray read-valid while idle has no effect
    @(negedge clk);
    mem_rvalid = 1'b1;
    mem_rdata  = 8'hA5;
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk("R9", "stray rvalid rsp", 32'(rsp_valid), 32'd0);
    chk("R9", "stray rvalid ready", 32'(req_ready), 32'd1);
    chk("R9", "stray rvalid mem_req", 32'(mem_req), 32'd0);

    set_base(16'h0200);
    xlate(5'd3, 10'h111, 2'b00, 0, -1, 16'h0, "R4 switched table");
    xlate(5'd3, 10'h112, 2'b00, 1, 0, 16'h0300, "R4 same-edge write");
    xlate(5'd3, 10'h113, 2'b01, 0, 1, 16'h0100, "R4 new base after write");
    xlate(5'd3, 10'h114, 2'b01, 2, -1, 16'h0, "R4 mid-walk write applied");

    set_base(16'hFFF0);
    xlate(5'd31, 10'h2C2, 2'b01, 1, -1, 16'h0, "R3 address wrap");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule